// File: doc/BRIEF.md
# Memory-Mapped Sixty-Four-Source Interrupt Controller

This block gathers up to 64 interrupt sources and drives two processor interrupt lines: a normal request line and a fast request line. Software configures it through a simple 32-bit register bus made of an address, a write enable, write data and read data. Every 64-bit control or status vector is seen as two 32-bit words. The word for sources 0 to 31 sits at the register's base offset. The word for sources 32 to 63 sits 4 bytes above it.

Each source is fixed as level or edge sensitive by a build-time parameter, and software can only read that choice back. An edge source records its event in a latch, which stays set until software clears it by writing a 1. A polarity register selects the active level or edge. A both-edges register makes either transition set the latch. Software can also force any source pending through a soft-request register. Pending sources pass through an enable mask and are then routed to the normal or the fast line. Each line is the registered OR of its status bits.

The usual handler flow is as follows. Read the normal-status low word, and if it is zero read the high word. Service the lowest set bit. For an edge source, clear its latch. Repeat until both words read zero.

Top module: `irq_hub64`

## Requirements
- R1: Each 64-bit vector has its sources 0..31 at the base offset and its sources 32..63 at base+4 (address bit 2 selects the upper word). The base offsets are fixed because software decodes them:
  - 0x00: normal status
  - 0x08: fast status
  - 0x10: raw pending
  - 0x18: route
  - 0x20: enable-set
  - 0x28: enable-clear
  - 0x30: soft-set
  - 0x38: soft-clear
  - 0x40: sense
  - 0x48: both-edges
  - 0x50: polarity
  - 0x58: latch-clear
  - 0x60: latch status
- R2: After reset the following are 0: enables, soft requests, route bits, both-edge bits, edge latches, irq_o and fiq_o. The polarity register resets to all ones.
- R3: Writing to enable-set sets each enable whose data bit is 1. Writing to enable-clear clears each enable whose data bit is 1. Zero bits in either write change nothing. The enable-set offset reads back the enables, and the enable-clear offset reads 0.
- R4: The soft-set and soft-clear offsets set and clear soft requests in the same write-1 way. Soft-set reads back the soft requests, and writing all ones to soft-clear removes every request. A soft request makes its source pending whatever its input does.
- R5: The route register is read/write. A route bit of 0 sends the source to the normal line, and a route bit of 1 sends it to the fast line.
- R6: The sense offset reads the LEVEL_SRC parameter: a 1 marks a level source and a 0 marks an edge source. Writes to the sense offset are ignored.
- R7: An edge source's latch is set on the selected transition of its input: rising when its polarity bit is 1, falling when it is 0, and either transition when its both-edges bit is 1. The latch holds until a 1 is written to its latch-clear bit. If a transition and a clear arrive in the same cycle, the latch stays set. The latch-status offset reads the latches.
- R8: A level source is pending while its input equals its polarity bit. Its latch is always 0, and writing its latch-clear bit has no effect.
- R9: The raw-pending offset reads the pending vector (input hit OR soft request) before masking. Normal status equals pending & enable & ~route. Fast status equals pending & enable & route.
- R10: irq_o is the OR of all normal-status bits and fiq_o is the OR of all fast-status bits, each registered. A line rises at the first clock edge at which its status is non-zero.
- R11: Reads of undefined offsets return 0, and reads with address bits [1:0] non-zero also return 0. Writes to undefined offsets change nothing.
- R12: An edge is detected at the clock edge where src_i differs from the value it had at the previous clock edge. The latch is set at that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NSRC | Interrupt source inputs, synchronous to clk |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_we | input | 1 | Write strobe, one write per cycle high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Normal interrupt request line |
| fiq_o | output | 1 | Fast interrupt request line |

## Verification
The assertions assume that src_i is already synchronous to clk and is held low through reset. Without that, the first edge seen after reset would be an artefact. They also assume that bus_we is a single-cycle strobe carrying a stable address and stable data. The directed tasks drive every input half a period away from the active edge, keep the sources low during reset, and clear every edge latch and enable before moving to the next scenario. This keeps the property windows free of left-over events.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
    localparam int WORD_W = 32;

    // Base word offsets; bit 2 of the address picks the upper word.
    localparam logic [7:0] REG_IRQ_STAT  = 8'h00;
    localparam logic [7:0] REG_FIQ_STAT  = 8'h08;
    localparam logic [7:0] REG_RAW       = 8'h10;
    localparam logic [7:0] REG_ROUTE     = 8'h18;
    localparam logic [7:0] REG_EN_SET    = 8'h20;
    localparam logic [7:0] REG_EN_CLR    = 8'h28;
    localparam logic [7:0] REG_SW_SET    = 8'h30;
    localparam logic [7:0] REG_SW_CLR    = 8'h38;
    localparam logic [7:0] REG_SENSE     = 8'h40;
    localparam logic [7:0] REG_BOTH      = 8'h48;
    localparam logic [7:0] REG_POL       = 8'h50;
    localparam logic [7:0] REG_LATCH_CLR = 8'h58;
    localparam logic [7:0] REG_LATCH     = 8'h60;
endpackage

// File: rtl/irq_hub_source.sv
module irq_hub_source #(
    parameter bit LEVEL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic pol_i,
    input  logic both_i,
    input  logic clr_i,
    output logic hit_o,
    output logic latch_o
);
    logic prev_q;
    logic latch_q;
    logic rise;
    logic fall;
    logic edge_hit;

    assign rise     = src_i & ~prev_q;
    assign fall     = ~src_i & prev_q;
    assign edge_hit = both_i ? (rise | fall) : (pol_i ? rise : fall);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            latch_q <= 1'b0;
        end else begin
            prev_q  <= src_i;
            latch_q <= LEVEL ? 1'b0 : (edge_hit | (latch_q & ~clr_i));
        end
    end

    assign hit_o   = LEVEL ? (src_i == pol_i) : latch_q;
    assign latch_o = latch_q;

    // R7: a set latch holds until a clear arrives
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_q && !clr_i) |=> latch_q);

    // R7: an edge in the clear cycle keeps the latch set
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_hit && !LEVEL) |=> latch_q);

    // R12: a latch rises only after a change of the sampled input
    a_r12_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(latch_q) |-> (prev_q != $past(prev_q)));
endmodule

// File: rtl/irq_hub_regs.sv
module irq_hub_regs
    import irq_hub_pkg::*;
#(
    parameter int              NSRC      = 64,
    parameter int              ADDR_W    = 8,
    parameter logic [NSRC-1:0] LEVEL_SRC = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [NSRC-1:0]   raw_i,
    input  logic [NSRC-1:0]   latch_i,
    input  logic [NSRC-1:0]   irq_stat_i,
    input  logic [NSRC-1:0]   fiq_stat_i,
    output logic [NSRC-1:0]   en_o,
    output logic [NSRC-1:0]   sw_o,
    output logic [NSRC-1:0]   route_o,
    output logic [NSRC-1:0]   pol_o,
    output logic [NSRC-1:0]   both_o,
    output logic [NSRC-1:0]   lclr_o
);
    localparam logic [ADDR_W-1:0] HI_BIT = ADDR_W'(4);

    logic              hi;
    logic              aligned;
    logic [ADDR_W-1:0] key;
    logic [63:0]       w64;
    logic [NSRC-1:0]   wv;
    logic              wr_en_set, wr_en_clr, wr_sw_set, wr_sw_clr;
    logic              wr_route, wr_pol, wr_both, wr_lclr;

    assign hi      = addr[2];
    assign aligned = (addr[1:0] == 2'b00);
    assign key     = addr & ~HI_BIT;
    assign w64     = hi ? {wdata, 32'h0} : {32'h0, wdata};
    assign wv      = w64[NSRC-1:0];

    assign wr_en_set = we && aligned && (key == ADDR_W'(REG_EN_SET));
    assign wr_en_clr = we && aligned && (key == ADDR_W'(REG_EN_CLR));
    assign wr_sw_set = we && aligned && (key == ADDR_W'(REG_SW_SET));
    assign wr_sw_clr = we && aligned && (key == ADDR_W'(REG_SW_CLR));
    assign wr_route  = we && aligned && (key == ADDR_W'(REG_ROUTE));
    assign wr_pol    = we && aligned && (key == ADDR_W'(REG_POL));
    assign wr_both   = we && aligned && (key == ADDR_W'(REG_BOTH));
    assign wr_lclr   = we && aligned && (key == ADDR_W'(REG_LATCH_CLR));

    assign lclr_o = wr_lclr ? wv : '0;

    function automatic logic [NSRC-1:0] put_word(input logic [NSRC-1:0] v,
                                                 input logic h,
                                                 input logic [WORD_W-1:0] w);
        logic [63:0] t;
        t = 64'(v);
        if (h) t[63:32] = w;
        else   t[31:0]  = w;
        return t[NSRC-1:0];
    endfunction

    function automatic logic [WORD_W-1:0] pick(input logic [NSRC-1:0] v,
                                               input logic h);
        logic [63:0] t;
        t = 64'(v);
        return h ? t[63:32] : t[31:0];
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_o    <= '0;
            sw_o    <= '0;
            route_o <= '0;
            both_o  <= '0;
            pol_o   <= '1;
        end else begin
            if (wr_en_set) en_o <= en_o | wv;
            if (wr_en_clr) en_o <= en_o & ~wv;
            if (wr_sw_set) sw_o <= sw_o | wv;
            if (wr_sw_clr) sw_o <= sw_o & ~wv;
            if (wr_route)  route_o <= put_word(route_o, hi, wdata);
            if (wr_pol)    pol_o   <= put_word(pol_o, hi, wdata);
            if (wr_both)   both_o  <= put_word(both_o, hi, wdata);
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            case (key)
                ADDR_W'(REG_IRQ_STAT): rdata = pick(irq_stat_i, hi);
                ADDR_W'(REG_FIQ_STAT): rdata = pick(fiq_stat_i, hi);
                ADDR_W'(REG_RAW):      rdata = pick(raw_i, hi);
                ADDR_W'(REG_ROUTE):    rdata = pick(route_o, hi);
                ADDR_W'(REG_EN_SET):   rdata = pick(en_o, hi);
                ADDR_W'(REG_SW_SET):   rdata = pick(sw_o, hi);
                ADDR_W'(REG_SENSE):    rdata = pick(LEVEL_SRC, hi);
                ADDR_W'(REG_BOTH):     rdata = pick(both_o, hi);
                ADDR_W'(REG_POL):      rdata = pick(pol_o, hi);
                ADDR_W'(REG_LATCH):    rdata = pick(latch_i, hi);
                default:               rdata = '0;
            endcase
        end
    end

    // R3: every 1 bit written to enable-set is an enable afterwards
    a_r3_en_set: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_set |=> ((en_o & $past(wv)) == $past(wv)));

    // R3: every 1 bit written to enable-clear is cleared afterwards
    a_r3_en_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_clr |=> ((en_o & $past(wv)) == '0));

    // R4: soft-clear removes the requests it names
    a_r4_sw_clr: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sw_clr |=> ((sw_o & $past(wv)) == '0));

    // R3: without an enable write the enables do not move
    a_r3_en_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en_set && !wr_en_clr) |=> $stable(en_o));
endmodule

// File: rtl/irq_hub64.sv
module irq_hub64
    import irq_hub_pkg::*;
#(
    parameter int              NSRC      = 64,
    parameter int              ADDR_W    = 8,
    parameter logic [NSRC-1:0] LEVEL_SRC = 64'hF000_0000_0000_000F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);
    logic [NSRC-1:0] en, sw, route, pol, both, lclr;
    logic [NSRC-1:0] hit, latch, raw, irq_stat, fiq_stat;
    logic            irq_q, fiq_q;

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_hub_source #(.LEVEL(LEVEL_SRC[i])) u_src (
            .clk    (clk),
            .rst_n  (rst_n),
            .src_i  (src_i[i]),
            .pol_i  (pol[i]),
            .both_i (both[i]),
            .clr_i  (lclr[i]),
            .hit_o  (hit[i]),
            .latch_o(latch[i])
        );
    end

    assign raw      = hit | sw;
    assign irq_stat = raw & en & ~route;
    assign fiq_stat = raw & en & route;

    irq_hub_regs #(
        .NSRC     (NSRC),
        .ADDR_W   (ADDR_W),
        .LEVEL_SRC(LEVEL_SRC)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .raw_i     (raw),
        .latch_i   (latch),
        .irq_stat_i(irq_stat),
        .fiq_stat_i(fiq_stat),
        .en_o      (en),
        .sw_o      (sw),
        .route_o   (route),
        .pol_o     (pol),
        .both_o    (both),
        .lclr_o    (lclr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            fiq_q <= 1'b0;
        end else begin
            irq_q <= |irq_stat;
            fiq_q <= |fiq_stat;
        end
    end

    assign irq_o = irq_q;
    assign fiq_o = fiq_q;

    // R10: the normal line needs an enabled source routed to it one cycle before
    a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> $past(|(en & ~route)));

    // R10: the fast line needs an enabled source routed to it one cycle before
    a_r10_fiq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> $past(|(en & route)));

    // R8: level sources never hold a latch
    a_r8_level_no_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (latch & LEVEL_SRC) == '0);
endmodule

// File: tb/test_irq_hub64.sv
module test_irq_hub64;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src = '0;
    logic [7:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_o, fiq_o;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_hub64 i_irq_hub64 (
        .clk(clk), .rst_n(rst_n), .src_i(src), .bus_addr(addr),
        .bus_we(we), .bus_wdata(wdata), .bus_rdata(rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        addr = a;
        #1;
        check(tag, rdata, exp);
    endtask

    task automatic t_reset;
        tick(1);
        rd_chk("R2 irq status lo", 8'h00, 32'h0);
        rd_chk("R2 enable lo", 8'h20, 32'h0);
        rd_chk("R2 route hi", 8'h1C, 32'h0);
        rd_chk("R2 latch lo", 8'h60, 32'h0);
        rd_chk("R2 polarity lo", 8'h50, 32'hFFFF_FFFF);
        check("R2 irq_o", {31'b0, irq_o}, 32'h0);
        check("R2 fiq_o", {31'b0, fiq_o}, 32'h0);
        rd_chk("R6 sense lo", 8'h40, 32'h0000_000F);
        rd_chk("R6 sense hi", 8'h44, 32'hF000_0000);
    endtask

    task automatic t_enable;
        wr(8'h20, 32'h00FF_00F0);
        rd_chk("R3 set", 8'h20, 32'h00FF_00F0);
        wr(8'h20, 32'h0F00_0000);
        rd_chk("R3 set keeps others", 8'h20, 32'h0FFF_00F0);
        wr(8'h28, 32'h0000_00F0);
        rd_chk("R3 clear", 8'h20, 32'h0FFF_0000);
        rd_chk("R3 clear reads 0", 8'h28, 32'h0);
        wr(8'h24, 32'h0000_0001);
        rd_chk("R1 high word", 8'h24, 32'h1);
        rd_chk("R1 low word untouched", 8'h20, 32'h0FFF_0000);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h2C, 32'hFFFF_FFFF);
        rd_chk("R3 clear all", 8'h20, 32'h0);
    endtask

    task automatic t_level;
        wr(8'h20, 32'h1);
        @(negedge clk);
        src[0] = 1'b1;
        #1;
        check("R10 irq_o before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        check("R10 irq_o after one edge", {31'b0, irq_o}, 32'h1);
        rd_chk("R9 raw", 8'h10, 32'h1);
        rd_chk("R8 level pending", 8'h00, 32'h1);
        wr(8'h58, 32'h1);
        rd_chk("R8 latch-clear no effect", 8'h00, 32'h1);
        rd_chk("R8 no latch", 8'h60, 32'h0);
        src[0] = 1'b0;
        tick(2);
        check("R8 irq_o drops", {31'b0, irq_o}, 32'h0);
        wr(8'h50, 32'hFFFF_FFFE);
        rd_chk("R8 active-low level", 8'h00, 32'h1);
        wr(8'h50, 32'hFFFF_FFFF);
        rd_chk("R8 polarity restored", 8'h00, 32'h0);
        wr(8'h28, 32'h1);
    endtask

    task automatic t_edge;
        wr(8'h20, 32'h10);
        @(negedge clk); src[4] = 1'b1;
        @(negedge clk); src[4] = 1'b0;
        tick(2);
        rd_chk("R12 rise latched", 8'h60, 32'h10);
        rd_chk("R7 status from latch", 8'h00, 32'h10);
        check("R10 irq_o edge", {31'b0, irq_o}, 32'h1);
        tick(5);
        rd_chk("R7 latch holds", 8'h60, 32'h10);
        wr(8'h58, 32'h10);
        rd_chk("R7 latch cleared", 8'h60, 32'h0);
        tick(1);
        check("R7 irq_o drops", {31'b0, irq_o}, 32'h0);
        wr(8'h50, 32'hFFFF_FFEF);
        @(negedge clk); src[4] = 1'b1;
        tick(2);
        rd_chk("R7 rise ignored when falling", 8'h60, 32'h0);
        src[4] = 1'b0;
        tick(2);
        rd_chk("R7 fall latched", 8'h60, 32'h10);
        wr(8'h58, 32'h10);
        wr(8'h50, 32'hFFFF_FFFF);
        wr(8'h48, 32'h10);
        @(negedge clk); src[4] = 1'b1;
        tick(2);
        rd_chk("R7 both: rise", 8'h60, 32'h10);
        @(negedge clk);
        src[4] = 1'b0; addr = 8'h58; wdata = 32'h10; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
        rd_chk("R7 set wins over clear", 8'h60, 32'h10);
        wr(8'h58, 32'h10);
        rd_chk("R7 cleared again", 8'h60, 32'h0);
        wr(8'h48, 32'h0);
        wr(8'h28, 32'h10);
    endtask

    task automatic t_soft_route;
        wr(8'h34, 32'h100);
        rd_chk("R4 soft readback", 8'h34, 32'h100);
        rd_chk("R9 raw unmasked", 8'h14, 32'h100);
        rd_chk("R9 masked status", 8'h04, 32'h0);
        wr(8'h24, 32'h100);
        tick(1);
        rd_chk("R4 soft pending", 8'h04, 32'h100);
        check("R5 irq_o", {31'b0, irq_o}, 32'h1);
        check("R5 fiq_o idle", {31'b0, fiq_o}, 32'h0);
        wr(8'h1C, 32'h100);
        tick(1);
        rd_chk("R5 route readback", 8'h1C, 32'h100);
        rd_chk("R5 normal empty", 8'h04, 32'h0);
        rd_chk("R5 fast status", 8'h0C, 32'h100);
        check("R5 fiq_o", {31'b0, fiq_o}, 32'h1);
        check("R5 irq_o idle", {31'b0, irq_o}, 32'h0);
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd_chk("R4 clear all", 8'h34, 32'h0);
        tick(1);
        check("R4 fiq_o drops", {31'b0, fiq_o}, 32'h0);
        wr(8'h1C, 32'h0);
        wr(8'h2C, 32'h100);
    endtask

    task automatic t_undefined;
        wr(8'h68, 32'hFFFF_FFFF);
        rd_chk("R11 undefined reads 0", 8'h68, 32'h0);
        rd_chk("R11 misaligned reads 0", 8'h51, 32'h0);
        wr(8'h40, 32'h0);
        rd_chk("R6 sense ignores write", 8'h40, 32'h0000_000F);
        rd_chk("R11 no side effect", 8'h20, 32'h0);
    endtask

    initial begin
        fork
            begin
                repeat (200000) @(posedge clk);
                if (!done) begin
                    errors++;
                    $display("FAIL watchdog: got timeout expected completion");
                    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                    $finish;
                end
            end
        join_none
        tick(5);
        rst_n = 1'b1;
        t_reset();
        t_enable();
        t_level();
        t_edge();
        t_soft_route();
        t_undefined();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule